// File: doc/BRIEF.md
# Real-Time Clock Timebase and Interrupt Controller

This block is a byte-addressed real-time clock core. It keeps a 64-byte register space: ten calendar bytes, four control and status bytes and fifty bytes of general-purpose storage. A clock-enable pulse at 32.768 kHz drives two dividers. The first produces a once-per-second update of the calendar. The second produces a periodic interrupt whose rate software selects with a 4-bit code.

The host reads and writes single bytes through an address, a write strobe and a read strobe. Read data is combinational from the address. The read strobe is used only for the side effects of a read: it clears the flag byte and it re-validates the valid bit.

The core provides several ways for software to follow or control updates:
- An update-in-progress bit warns software a fixed number of ticks before each update.
- An inhibit bit aborts any pending update and holds the calendar still.
- A flag byte shows periodic and update events and is cleared by reading it.
- An external battery-fail input clears a valid bit.

All counts are binary. All time is measured in clock-enable ticks, so the bench can compress one second to a few ticks.

Top module: `rtc_core`

## Requirements
- R1: After reset the register bytes read as follows:
  - control A = 0x20, control B = 0x02, flags = 0x00, valid byte = 0x80;
  - seconds = minutes = hours = 0;
  - weekday = 1, day = 1, month = 1, year = 0.
  The map is: 0 seconds, 1 seconds-alarm, 2 minutes, 3 minutes-alarm, 4 hours, 5 hours-alarm, 6 weekday, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 flags, 13 valid byte.
- R2: Addresses 14 to 63 are fifty read/write storage bytes. The three alarm bytes (1, 3, 5) are plain storage with no effect.
- R3: Control A bits 3:0 select the periodic flag interval in ticks:
  - code 0: never;
  - code 1: 128 ticks;
  - code 2: 256 ticks;
  - codes 3 to 15: 2^(code-1) ticks.
- R4: The update-in-progress bit (control A bit 7) rises UIP_LEAD_TICKS ticks before each second boundary. It stays high for UPDATE_TICKS ticks after the boundary and falls when the calendar advances.
- R5: Counting from reset or from the release of the inhibit bit, the calendar first advances after TICKS_PER_SEC+UPDATE_TICKS ticks. After that it advances every TICKS_PER_SEC ticks.
- R6: Control B bit 7 (inhibit) does three things:
  - it forces the update-in-progress bit low;
  - it aborts an update already under way;
  - it freezes the calendar and restarts the second count, which begins again when the bit is cleared.
- R7: The flag byte has bit 7 = request, bit 6 = periodic flag, bit 5 = 0, bit 4 = update flag, bits 3:0 = 0.
  - The periodic flag sets at each periodic interval.
  - The update flag sets at each calendar advance.
  - The request bit and the irq_o pin equal (periodic AND control B bit 6) OR (update AND control B bit 4).
- R8: A strobed read of the flag byte returns its value and then clears both flags, which drops irq_o.
- R9: Valid byte bit 7 clears while batt_fail is high. Any strobed read of the valid byte sets it to one afterwards. Bits 6:0 read zero.
- R10: The 24-hour calendar (control B bit 1 = 1) rolls over as follows:
  - seconds and minutes roll over after 59, and hours after 23;
  - the weekday runs 1..7;
  - the day of month runs up to 30 or 31 by month, with February at 28 days, or 29 when the year is divisible by four;
  - the month runs 1..12 and a carry out of December increments the year;
  - the year wraps from 99 to 0.
- R11: With control B bit 1 = 0, hours run 12, 1..11. Bit 7 of the hours byte marks PM. It toggles on the step from 11 to 12, and the day advances on the step from 11 PM to 12 AM.
- R12: The time base is enabled only when control A bits 6:4 equal 010. With any other value, neither the calendar nor the periodic flag advances.
- R13: Writes to the flag byte and the valid byte are ignored, as are writes to control A bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle time-base enable, nominally 32.768 kHz |
| batt_fail | input | 1 | Battery-loss indication, clears the valid bit |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the core with TICKS_PER_SEC = 16, UIP_LEAD_TICKS = 2 and UPDATE_TICKS = 4. With those values a simulated second takes sixteen ticks, so the bench can sweep the update-in-progress window and the second count tick by tick over three seconds. It can also walk every month end, in both leap and common years, and every hour in 12-hour mode. The periodic divider keeps its full width, so the bench times all fifteen rate codes exactly, the 500 ms code included.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned IX_SEC     = 0;
   localparam int unsigned IX_SEC_AL  = 1;
   localparam int unsigned IX_MIN     = 2;
   localparam int unsigned IX_MIN_AL  = 3;
   localparam int unsigned IX_HOUR    = 4;
   localparam int unsigned IX_HOUR_AL = 5;
   localparam int unsigned IX_WDAY    = 6;
   localparam int unsigned IX_MDAY    = 7;
   localparam int unsigned IX_MONTH   = 8;
   localparam int unsigned IX_YEAR    = 9;
   localparam int unsigned IX_CTLA    = 10;
   localparam int unsigned IX_CTLB    = 11;
   localparam int unsigned IX_FLAGS   = 12;
   localparam int unsigned IX_VALID   = 13;
   localparam int unsigned IX_RAM0    = 14;
   localparam int unsigned NUM_CAL    = 10;

   // control B, bit 7 down to bit 0
   typedef struct packed {
      logic set_inh;
      logic per_en;
      logic alm_en;
      logic upd_en;
      logic sqw_en;
      logic bin_mode;
      logic h24;
      logic dst_en;
   } ctlb_t;

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
      case (mon)
         8'd2:                      return leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
         default:                   return 8'd31;
      endcase
   endfunction

   // log2 of the periodic interval in ticks; 0 means disabled
   function automatic logic [3:0] rate_shift(input logic [3:0] code);
      case (code)
         4'd0:    return 4'd0;
         4'd1:    return 4'd7;
         4'd2:    return 4'd8;
         default: return code - 4'd1;
      endcase
   endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase import rtc_pkg::*; #(
   parameter int unsigned SEC_TICKS  = 32768,
   parameter int unsigned LEAD_TICKS = 8,
   parameter int unsigned BUSY_TICKS = 64,
   parameter int unsigned PDIV_W     = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic       hold,
   input  logic [3:0] rate,
   output logic       uip,
   output logic       commit,
   output logic       per_pulse
);
   localparam int unsigned SUB_W = (SEC_TICKS > 2) ? $clog2(SEC_TICKS) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(SEC_TICKS - 1);
   localparam logic [SUB_W-1:0] SUB_LEAD  = SUB_W'(SEC_TICKS - LEAD_TICKS);
   localparam logic [SUB_W-1:0] BUSY_LAST = SUB_W'(BUSY_TICKS - 1);

   generate
      if (LEAD_TICKS + BUSY_TICKS >= SEC_TICKS)
         $error("rtc_timebase: lead plus update window must fit in one second");
      if (LEAD_TICKS == 0 || BUSY_TICKS == 0)
         $error("rtc_timebase: lead and update windows must be non-zero");
      if (PDIV_W < 14)
         $error("rtc_timebase: periodic divider needs at least 14 bits");
   endgenerate

   logic [SUB_W-1:0]  sub_q;
   logic              busy_q;
   logic [PDIV_W-1:0] pcnt_q;
   logic [PDIV_W-1:0] pmask;
   logic              step;

   assign step = tick & run;

   always_comb begin
      logic [PDIV_W-1:0] one_w;
      one_w = PDIV_W'(1);
      pmask = (one_w << rate_shift(rate)) - one_w;
   end

   assign commit    = step && !hold && busy_q && (sub_q == BUSY_LAST);
   assign per_pulse = step && (rate != 4'd0) && ((pcnt_q & pmask) == pmask);
   assign uip       = !hold && (busy_q || (sub_q >= SUB_LEAD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_q  <= '0;
         busy_q <= 1'b0;
         pcnt_q <= '0;
      end else begin
         if (step)
            pcnt_q <= pcnt_q + 1'b1;
         if (hold) begin
            sub_q  <= '0;
            busy_q <= 1'b0;
         end else if (step) begin
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
            if (sub_q == SUB_LAST)
               busy_q <= 1'b1;
            else if (commit)
               busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; #(
   parameter bit LEAP_EVERY4 = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  logic                     h24,
   input  logic                     wr,
   input  logic [3:0]               widx,
   input  logic [7:0]               wdata,
   output logic [NUM_CAL-1:0][7:0]  cal_q
);
   logic [NUM_CAL-1:0][7:0] nxt;
   logic                    leap;
   logic [7:0]              hour_nxt;
   logic                    day_carry;

   generate
      if (LEAP_EVERY4) begin : g_leap4
         assign leap = (cal_q[IX_YEAR][1:0] == 2'b00);
      end else begin : g_noleap
         assign leap = 1'b0;
      end
   endgenerate

   always_comb begin
      logic [7:0] hr;
      hr = cal_q[IX_HOUR];
      if (h24) begin
         day_carry = (hr >= 8'd23);
         hour_nxt  = day_carry ? 8'd0 : hr + 8'd1;
      end else if (hr[6:0] == 7'd11) begin
         day_carry = hr[7];
         hour_nxt  = {~hr[7], 7'd12};
      end else if (hr[6:0] >= 7'd12) begin
         day_carry = 1'b0;
         hour_nxt  = {hr[7], 7'd1};
      end else begin
         day_carry = 1'b0;
         hour_nxt  = {hr[7], hr[6:0] + 7'd1};
      end
   end

   always_comb begin
      nxt = cal_q;
      if (cal_q[IX_SEC] < 8'd59) begin
         nxt[IX_SEC] = cal_q[IX_SEC] + 8'd1;
      end else begin
         nxt[IX_SEC] = 8'd0;
         if (cal_q[IX_MIN] < 8'd59) begin
            nxt[IX_MIN] = cal_q[IX_MIN] + 8'd1;
         end else begin
            nxt[IX_MIN]  = 8'd0;
            nxt[IX_HOUR] = hour_nxt;
            if (day_carry) begin
               nxt[IX_WDAY] = (cal_q[IX_WDAY] >= 8'd7) ? 8'd1 : cal_q[IX_WDAY] + 8'd1;
               if (cal_q[IX_MDAY] < month_len(cal_q[IX_MONTH], leap)) begin
                  nxt[IX_MDAY] = cal_q[IX_MDAY] + 8'd1;
               end else begin
                  nxt[IX_MDAY] = 8'd1;
                  if (cal_q[IX_MONTH] < 8'd12) begin
                     nxt[IX_MONTH] = cal_q[IX_MONTH] + 8'd1;
                  end else begin
                     nxt[IX_MONTH] = 8'd1;
                     nxt[IX_YEAR]  = (cal_q[IX_YEAR] >= 8'd99) ? 8'd0 : cal_q[IX_YEAR] + 8'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_q           <= '0;
         cal_q[IX_WDAY]  <= 8'd1;
         cal_q[IX_MDAY]  <= 8'd1;
         cal_q[IX_MONTH] <= 8'd1;
      end else begin
         if (commit)
            cal_q <= nxt;
         if (wr)
            cal_q[widx] <= wdata;
      end
   end

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic per_pulse,
   input  logic commit,
   input  logic rd_clr,
   input  logic pie,
   input  logic uie,
   output logic pf,
   output logic uf,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf <= 1'b0;
         uf <= 1'b0;
      end else begin
         if (per_pulse)   pf <= 1'b1;
         else if (rd_clr) pf <= 1'b0;
         if (commit)      uf <= 1'b1;
         else if (rd_clr) uf <= 1'b0;
      end
   end

   assign irq = (pf & pie) | (uf & uie);

endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
   parameter int unsigned TICKS_PER_SEC  = 32768,
   parameter int unsigned UIP_LEAD_TICKS = 8,
   parameter int unsigned UPDATE_TICKS   = 64,
   parameter int unsigned RAM_BYTES      = 50,
   parameter int unsigned ADDR_W         = 6,
   parameter bit          LEAP_EVERY4    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic              batt_fail,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_o
);
   localparam int unsigned NUM_REGS = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_CTLA  = ADDR_W'(IX_CTLA);
   localparam logic [ADDR_W-1:0] A_CTLB  = ADDR_W'(IX_CTLB);
   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(IX_FLAGS);
   localparam logic [ADDR_W-1:0] A_VALID = ADDR_W'(IX_VALID);

   generate
      if (IX_RAM0 + RAM_BYTES > NUM_REGS)
         $error("rtc_core: storage bytes exceed the address space");
      if (ADDR_W < 4)
         $error("rtc_core: address must reach the control bytes");
   endgenerate

   logic [6:0]              ctla_q;
   ctlb_t                   ctlb_q;
   logic                    vrt_q;
   logic [NUM_CAL-1:0][7:0] cal_q;
   logic [7:0]              ram_q [RAM_BYTES];
   logic                    uip, upd_commit, per_tick;
   logic                    pf, uf, irq;
   logic                    cal_we, flags_rd;

   assign cal_we   = bus_wr && (bus_addr < ADDR_W'(NUM_CAL));
   assign flags_rd = bus_rd && (bus_addr == A_FLAGS);

   rtc_timebase #(
      .SEC_TICKS  (TICKS_PER_SEC),
      .LEAD_TICKS (UIP_LEAD_TICKS),
      .BUSY_TICKS (UPDATE_TICKS),
      .PDIV_W     (14)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_32k),
      .run       (ctla_q[6:4] == 3'b010),
      .hold      (ctlb_q.set_inh),
      .rate      (ctla_q[3:0]),
      .uip       (uip),
      .commit    (upd_commit),
      .per_pulse (per_tick)
   );

   rtc_calendar #(.LEAP_EVERY4(LEAP_EVERY4)) u_cal (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (upd_commit),
      .h24    (ctlb_q.h24),
      .wr     (cal_we),
      .widx   (bus_addr[3:0]),
      .wdata  (bus_wdata),
      .cal_q  (cal_q)
   );

   rtc_flags u_flg (
      .clk       (clk),
      .rst_n     (rst_n),
      .per_pulse (per_tick),
      .commit    (upd_commit),
      .rd_clr    (flags_rd),
      .pie       (ctlb_q.per_en),
      .uie       (ctlb_q.upd_en),
      .pf        (pf),
      .uf        (uf),
      .irq       (irq)
   );

   assign irq_o = irq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctla_q <= 7'h20;
         ctlb_q <= ctlb_t'(8'h02);
         vrt_q  <= 1'b1;
      end else begin
         if (bus_wr && bus_addr == A_CTLA) ctla_q <= bus_wdata[6:0];
         if (bus_wr && bus_addr == A_CTLB) ctlb_q <= ctlb_t'(bus_wdata);
         if (batt_fail)
            vrt_q <= 1'b0;
         else if (bus_rd && bus_addr == A_VALID)
            vrt_q <= 1'b1;
      end
   end

   genvar g;
   generate
      for (g = 0; g < RAM_BYTES; g++) begin : g_ram
         always_ff @(posedge clk) begin
            if (!rst_n)
               ram_q[g] <= 8'h00;
            else if (bus_wr && bus_addr == ADDR_W'(IX_RAM0 + g))
               ram_q[g] <= bus_wdata;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = 8'h00;
      for (int i = 0; i < NUM_CAL; i++)
         if (bus_addr == ADDR_W'(i)) bus_rdata = cal_q[i];
      for (int i = 0; i < RAM_BYTES; i++)
         if (bus_addr == ADDR_W'(IX_RAM0 + i)) bus_rdata = ram_q[i];
      if (bus_addr == A_CTLA)  bus_rdata = {uip, ctla_q};
      if (bus_addr == A_CTLB)  bus_rdata = ctlb_q;
      if (bus_addr == A_FLAGS) bus_rdata = {irq, pf, 1'b0, uf, 4'h0};
      if (bus_addr == A_VALID) bus_rdata = {vrt_q, 7'h00};
   end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk import rtc_pkg::*; #(
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              batt_fail,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              irq_o,
   input logic              upd_commit,
   input logic              per_tick,
   input logic              uip,
   input logic [2:0]        dvx,
   input logic              set_inh,
   input logic              vrt_q,
   input logic [7:0]        sec_q,
   input logic [7:0]        min_q
);
   // R8
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(IX_FLAGS) && !per_tick && !upd_commit) |=> !irq_o);

   // R6
   inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_inh |-> (!upd_commit && !uip));

   // R4
   commit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_commit |-> uip);

   // R12
   divisor_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dvx != 3'b010) |-> (!upd_commit && !per_tick));

   // R9
   valid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(IX_VALID) && !batt_fail) |=> vrt_q);

   // R9
   valid_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      batt_fail |=> !vrt_q);

   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(per_tick) || $past(upd_commit) || $past(bus_wr)));

   // R10
   time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_q < 8'd60) && (min_q < 8'd60));

endmodule

bind rtc_core rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .batt_fail  (batt_fail),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .irq_o      (irq_o),
   .upd_commit (upd_commit),
   .per_tick   (per_tick),
   .uip        (uip),
   .dvx        (ctla_q[6:4]),
   .set_inh    (ctlb_q.set_inh),
   .vrt_q      (vrt_q),
   .sec_q      (cal_q[IX_SEC]),
   .min_q      (cal_q[IX_MIN])
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;
   localparam int TPS  = 16;
   localparam int LEAD = 2;
   localparam int BUSY = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       batt = 1'b0;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rtc_core #(
      .TICKS_PER_SEC  (TPS),
      .UIP_LEAD_TICKS (LEAD),
      .UPDATE_TICKS   (BUSY),
      .RAM_BYTES      (50),
      .ADDR_W         (6),
      .LEAP_EVERY4    (1'b1)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_32k  (tick),
      .batt_fail (batt),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 6'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input int a, output int v);
      bus_addr = 6'(a);
      #1 v = int'(bus_rdata);
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_addr = 6'(a); bus_rd = 1'b1;
      #1 v = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic set_time(input int hr, input int mi, input int s,
                           input int dw, input int d, input int mo, input int y);
      wr(0, s); wr(2, mi); wr(4, hr); wr(6, dw); wr(7, d); wr(8, mo); wr(9, y);
   endtask

   function automatic int dim(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic int enc12(input int h);
      int hh;
      hh = h % 12;
      if (hh == 0) hh = 12;
      return ((h >= 12) ? 128 : 0) + hh;
   endfunction

   initial begin : watchdog
      #(5.0 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(0, v); check("R1 seconds", v, 0);
      peek(2, v); check("R1 minutes", v, 0);
      peek(4, v); check("R1 hours", v, 0);
      peek(6, v); check("R1 weekday", v, 1);
      peek(7, v); check("R1 day", v, 1);
      peek(8, v); check("R1 month", v, 1);
      peek(9, v); check("R1 year", v, 0);
      peek(10, v); check("R1 control A", v, 8'h20);
      peek(11, v); check("R1 control B", v, 8'h02);
      peek(12, v); check("R1 flags", v, 0);
      peek(13, v); check("R1 valid", v, 8'h80);

      // R2 storage and alarm bytes
      for (int i = 14; i < 64; i++) wr(i, (i * 37 + 5) & 255);
      wr(1, 8'h5A); wr(3, 8'hA5); wr(5, 8'h3C);
      for (int i = 14; i < 64; i++) begin
         peek(i, v); check("R2 storage byte", v, (i * 37 + 5) & 255);
      end
      peek(1, v); check("R2 alarm byte 1", v, 8'h5A);
      peek(3, v); check("R2 alarm byte 3", v, 8'hA5);
      peek(5, v); check("R2 alarm byte 5", v, 8'h3C);

      // R4 / R5 sweep, second count still at zero since reset
      for (int k = 1; k <= 3 * TPS + BUSY; k++) begin
         int m, eu, es;
         ticks(1);
         m  = k % TPS;
         eu = (k >= TPS - LEAD) && ((m >= TPS - LEAD) || (m < BUSY));
         es = (k < TPS + BUSY) ? 0 : 1 + (k - TPS - BUSY) / TPS;
         peek(10, v); check("R4 update-in-progress", (v >> 7) & 1, eu);
         peek(0, v);  check("R5 seconds count", v, es);
      end

      // R6 inhibit and abort
      wr(11, 8'h82);
      wr(0, 10);
      wr(11, 8'h02);
      ticks(TPS + 1);
      peek(10, v); check("R6 window open before abort", (v >> 7) & 1, 1);
      wr(11, 8'h82);
      peek(10, v); check("R6 inhibit drops window", (v >> 7) & 1, 0);
      ticks(3 * TPS);
      peek(0, v); check("R6 frozen seconds", v, 10);
      wr(11, 8'h02);
      ticks(TPS + BUSY - 1);
      peek(0, v); check("R6 restart not yet", v, 10);
      ticks(1);
      peek(0, v); check("R6 restart advance", v, 11);

      // R10 month ends, leap and common years
      for (int yi = 0; yi < 3; yi++) begin
         int y;
         y = (yi == 0) ? 21 : (yi == 1) ? 24 : 99;
         for (int mo = 1; mo <= 12; mo++) begin
            if (yi == 2 && mo != 12) continue;
            wr(11, 8'h82);
            set_time(23, 59, 59, 7, dim(mo, y), mo, y);
            wr(11, 8'h02);
            ticks(TPS + BUSY);
            peek(0, v); check("R10 seconds wrap", v, 0);
            peek(2, v); check("R10 minutes wrap", v, 0);
            peek(4, v); check("R10 hours wrap", v, 0);
            peek(6, v); check("R10 weekday wrap", v, 1);
            peek(7, v); check("R10 day wrap", v, 1);
            peek(8, v); check("R10 month step", v, (mo == 12) ? 1 : mo + 1);
            peek(9, v); check("R10 year step", v, (mo == 12) ? ((y == 99) ? 0 : y + 1) : y);
         end
      end
      wr(11, 8'h82);
      set_time(23, 59, 59, 3, 28, 2, 24);
      wr(11, 8'h02);
      ticks(TPS + BUSY);
      peek(7, v); check("R10 leap day", v, 29);
      peek(6, v); check("R10 weekday step", v, 4);

      // R11 12-hour mode, every hour
      for (int h = 0; h < 24; h++) begin
         wr(11, 8'h80);
         set_time(enc12(h), 59, 59, 2, 10, 5, 30);
         wr(11, 8'h00);
         ticks(TPS + BUSY);
         peek(4, v); check("R11 hour step", v, enc12((h + 1) % 24));
         peek(7, v); check("R11 day carry", v, (h == 23) ? 11 : 10);
      end

      // R13 ignored writes
      wr(11, 8'h82);
      rd(12, v);
      wr(10, 8'hA5);
      peek(10, v); check("R13 control A bit 7 read-only", v, 8'h25);
      wr(10, 8'h20);
      wr(12, 8'hFF);
      peek(12, v); check("R13 flag write ignored", v, 0);
      wr(13, 8'h00);
      peek(13, v); check("R13 valid write ignored", v, 8'h80);

      // R9 valid bit
      @(negedge clk); batt = 1'b1;
      @(negedge clk); batt = 1'b0;
      peek(13, v); check("R9 cleared by battery loss", v, 0);
      rd(13, v);  check("R9 read returns cleared", v, 0);
      peek(13, v); check("R9 set by read", v, 8'h80);

      // R7 / R8 periodic flag with enable
      wr(11, 8'hC2);
      wr(10, 8'h23);
      rd(12, v);
      ticks(4);
      peek(12, v); check("R7 periodic with enable", v, 8'hC0);
      check("R7 irq pin high", int'(irq), 1);
      rd(12, v);  check("R8 read returns flags", v, 8'hC0);
      peek(12, v); check("R8 flags cleared", v, 0);
      check("R8 irq pin dropped", int'(irq), 0);
      wr(11, 8'h82);
      ticks(8);
      peek(12, v); check("R7 periodic without enable", v, 8'h40);
      check("R7 irq pin low", int'(irq), 0);
      // update flag
      wr(10, 8'h20);
      wr(11, 8'h92);
      rd(12, v);
      wr(11, 8'h12);
      ticks(TPS + BUSY - 1);
      peek(12, v); check("R7 update flag not yet", v, 0);
      ticks(1);
      peek(12, v); check("R7 update flag and request", v, 8'h90);
      check("R7 irq pin from update", int'(irq), 1);
      rd(12, v);
      check("R8 update cleared", int'(irq), 0);

      // R12 divisor gate
      wr(11, 8'h02);
      wr(10, 8'h03);
      rd(12, v);
      peek(0, v2);
      ticks(3 * TPS);
      peek(0, v); check("R12 time frozen", v, v2);
      peek(12, v); check("R12 no flags", v, 0);
      wr(10, 8'h20);

      // R3 periodic interval per rate code (code 0 first)
      rd(12, v);
      ticks(1000);
      peek(12, v); check("R3 code 0 never", (v >> 6) & 1, 0);
      for (int code = 1; code < 16; code++) begin
         int cnt, guard, exp;
         exp = (code == 1) ? 128 : (code == 2) ? 256 : (1 << (code - 1));
         wr(10, 8'h20 | code);
         rd(12, v);
         @(negedge clk);
         bus_addr = 6'd12; tick = 1'b1;
         guard = 0;
         forever begin
            @(negedge clk); #1;
            guard++;
            if (bus_rdata[6] || guard > 40000) break;
         end
         bus_rd = 1'b1;
         cnt = 0;
         forever begin
            @(negedge clk);
            bus_rd = 1'b0;
            #1 cnt++;
            if (bus_rdata[6] || cnt > 40000) break;
         end
         tick = 1'b0;
         check($sformatf("R3 interval code %0d", code), cnt, exp);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule